// File: doc/BRIEF.md
# Four-Lane Serial Memory Burst Reader

This block is the host side of a four-lane serial memory link. It reads only. A requester pulses `start` with a 24-bit start address, a byte count and a dummy-cycle count. The block then selects the device, which is active-low, and sends an 8-bit read opcode followed by the address. Both go out over four driven lanes. The block releases the lanes for the configured number of turnaround clocks and then collects data nibbles. Each pair of nibbles becomes one byte on a single-cycle valid/data stream. Only one address is sent per transaction: the device returns consecutive bytes for as long as the requested count lasts.

The serial clock runs at half the system clock. It idles low. Lanes are driven after falling edges and sampled on rising edges, so transfers are single data rate. With the default of four dummy cycles, the first byte is complete after 14 serial clocks: 2 for the opcode, 6 for the address, 4 dummy and 2 for data. Each further byte adds 2 serial clocks. After the last byte, chip select returns high and stays high for one serial period before the block accepts new work.

The controller is a five-state machine:
- `ST_IDLE` goes to `ST_SEND` when a start arrives with a non-zero count.
- `ST_SEND` goes to `ST_DUMMY` after the eighth header nibble. It goes straight to `ST_DATA` when the dummy count is zero.
- `ST_DUMMY` goes to `ST_DATA` after the last dummy clock.
- `ST_DATA` goes to `ST_TAIL` on the falling edge that follows the final byte.
- `ST_TAIL` goes back to `ST_IDLE` after two system clocks.

Top module: `qspi_burst_reader`

## Requirements
- R1: While `cs_n` is high, `sck` is low. While `cs_n` is low, `sck` toggles on every system clock, starting low, so one serial period is two system clocks.
- R2: The header is the opcode (default 8'hEB) followed by the 24-bit address, 32 bits in total. It is sent over 8 serial clocks, most significant nibble first, with `io_out[3]` carrying the highest bit of each nibble.
- R3: One accepted start yields exactly `nbytes` bytes. Byte i is the device byte at address `addr+i` (modulo 2^24), with no further address sent.
- R4: The dummy count D is sampled at start, and D serial clocks separate the header from the data. Taking the accepting clock edge as edge 0, the first `rd_valid` follows edge 2*(10+D)-1, which is 27 for D=4 (14 serial clocks).
- R5: Each further byte follows 4 system clocks (2 serial clocks) after the previous one. `rd_valid` is high for exactly one clock per byte.
- R6: `io_oe` is 4'hF during the header and 4'h0 from the first dummy clock until `cs_n` rises. It is 4'h0 while `cs_n` is high.
- R7: `cs_n` falls on edge 0, one system clock before the first rising `sck`. It rises one clock after the last `rd_valid` and stays high for 2 clocks before `busy` falls.
- R8: `busy` is high from edge 0 until the end of the idle gap. A `start` while `busy` is high is ignored.
- R9: A `start` with `nbytes` equal to zero is ignored: `busy` stays low and `cs_n` stays high.
- R10: Lanes are sampled on rising `sck`. The first nibble of a byte becomes `rd_data[7:4]` and the second becomes `rd_data[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst read (one-clock pulse) |
| addr | input | 24 | Start address |
| nbytes | input | 16 | Number of bytes to read |
| dummy_cycles | input | 5 | Turnaround serial clocks after the address |
| busy | output | 1 | Transaction in progress |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| rd_data | output | 8 | Received byte |
| cs_n | output | 1 | Device select, active low |
| sck | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The assertions check on every cycle the invariants that need no knowledge of the transaction:
- the serial clock idles low and always rises after a low half while the device is selected;
- the output enables are all-or-nothing and off while the device is deselected;
- `rd_valid` pulses for one clock, only after a rising edge and only while selected;
- a zero-count start leaves the block idle.

Only the bench's scenarios can show the rest:
- the order of the header bits;
- latency that depends on the dummy count;
- the byte count and address sequence of a burst;
- the spacing of bytes;
- the idle gap;
- that a start arriving mid-transaction is rejected.

// File: rtl/qsbr_pkg.sv
package qsbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DUMMY,
        ST_DATA,
        ST_TAIL
    } qsbr_state_t;

    localparam int NIB_BITS  = 4;
    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/qsbr_tx_shifter.sv
module qsbr_tx_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    output logic [3:0]        nib
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= word;
        end else if (shift) begin
            sr <= {sr[WORD_W-5:0], 4'h0};
        end
    end

    // Most significant nibble leads; lane 3 carries its top bit
    assign nib = sr[WORD_W-1 -: 4];
endmodule

// File: rtl/qsbr_rx_pack.sv
module qsbr_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       capture,
    input  logic [3:0] nib_in,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    logic [3:0] hi_q;
    logic       have_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q       <= '0;
            have_hi    <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (clear) begin
                have_hi <= 1'b0;
            end else if (capture) begin
                if (!have_hi) begin
                    hi_q    <= nib_in;
                    have_hi <= 1'b1;
                end else begin
                    byte_data  <= {hi_q, nib_in};
                    byte_valid <= 1'b1;
                    have_hi    <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/qspi_burst_reader.sv
module qspi_burst_reader #(
    parameter int          ADDR_W  = 24,
    parameter int          CNT_W   = 16,
    parameter int          DUMMY_W = 5,
    parameter logic [7:0]  RD_CMD  = 8'hEB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic [DUMMY_W-1:0] dummy_cycles,
    output logic               busy,
    output logic               rd_valid,
    output logic [7:0]         rd_data,
    output logic               cs_n,
    output logic               sck,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    import qsbr_pkg::*;

    localparam int HDR_W    = 8 + ADDR_W;
    localparam int HDR_NIBS = HDR_W / NIB_BITS;
    localparam int NIB_CW   = $clog2(HDR_NIBS);
    localparam logic [NIB_CW-1:0] LAST_NIB = NIB_CW'(HDR_NIBS - 1);

    qsbr_state_t state, state_nx;

    logic               ph;          // registered serial clock level
    logic [NIB_CW-1:0]  nib_cnt;
    logic [DUMMY_W-1:0] dcnt;
    logic [DUMMY_W-1:0] d_cfg;
    logic [CNT_W-1:0]   left;
    logic               tail_cnt;
    logic               active;
    logic               fall;
    logic               rise;
    logic               accept;
    logic               byte_valid;
    logic [7:0]         byte_data;

    assign active = (state == ST_SEND) || (state == ST_DUMMY) || (state == ST_DATA);
    assign fall   = active && ph;
    assign rise   = active && !ph;
    assign accept = (state == ST_IDLE) && start && (nbytes != '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_SEND;
            ST_SEND:  if (fall && nib_cnt == LAST_NIB)
                          state_nx = (d_cfg == '0) ? ST_DATA : ST_DUMMY;
            ST_DUMMY: if (fall && dcnt == DUMMY_W'(d_cfg - 1'b1))
                          state_nx = ST_DATA;
            ST_DATA:  if (fall && byte_valid && left == CNT_W'(1))
                          state_nx = ST_TAIL;
            ST_TAIL:  if (tail_cnt) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Counters and clock phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= 1'b0;
            nib_cnt  <= '0;
            dcnt     <= '0;
            d_cfg    <= '0;
            left     <= '0;
            tail_cnt <= 1'b0;
        end else begin
            ph <= (state_nx == ST_SEND || state_nx == ST_DUMMY || state_nx == ST_DATA)
                  && active ? ~ph : 1'b0;
            if (accept) begin
                nib_cnt  <= '0;
                dcnt     <= '0;
                d_cfg    <= dummy_cycles;
                left     <= nbytes;
                tail_cnt <= 1'b0;
            end else begin
                if (state == ST_SEND && fall)  nib_cnt <= nib_cnt + 1'b1;
                if (state == ST_DUMMY && fall) dcnt <= dcnt + 1'b1;
                if (byte_valid)                left <= left - 1'b1;
                if (state == ST_TAIL)          tail_cnt <= 1'b1;
            end
        end
    end

    qsbr_tx_shifter #(.WORD_W(HDR_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .word  ({RD_CMD, addr}),
        .shift (state == ST_SEND && fall),
        .nib   (io_out)
    );

    qsbr_rx_pack u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    (state == ST_DATA && rise),
        .nib_in     (io_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    // Outputs
    always_comb begin
        busy     = (state != ST_IDLE);
        cs_n     = !active;
        sck      = ph;
        io_oe    = (state == ST_SEND) ? 4'hF : 4'h0;
        rd_valid = byte_valid;
        rd_data  = byte_data;
    end
endmodule

// File: rtl/qsbr_checker.sv
module qsbr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] nbytes,
    input logic             busy,
    input logic             cs_n,
    input logic             sck,
    input logic [3:0]       io_oe,
    input logic             rd_valid
);
    a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r1_sck_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sck) |=> sck);

    a_r6_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(io_oe) == 0) || (io_oe == 4'hF));

    a_r6_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == 4'h0));

    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r10_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (sck && !cs_n));

    a_r8_busy_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r9_zero_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && nbytes == '0) |=> !busy);
endmodule

bind qspi_burst_reader qsbr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .nbytes   (nbytes),
    .busy     (busy),
    .cs_n     (cs_n),
    .sck      (sck),
    .io_oe    (io_oe),
    .rd_valid (rd_valid)
);

// File: tb/qspi_burst_reader_test.sv
`timescale 1ns/1ps
module qspi_burst_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] nbytes = '0;
    logic [4:0]  dummy_cycles = 5'd4;
    logic        busy, rd_valid, cs_n, sck;
    logic [7:0]  rd_data;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = 4'h0;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    qspi_burst_reader uut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .nbytes(nbytes),
        .dummy_cycles(dummy_cycles), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .cs_n(cs_n), .sck(sck), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // Device model: collects header, flags lane contention, returns data nibbles
    int          rc = 0;
    logic [31:0] hdr = '0;
    logic        oe_bad = 1'b0;
    int          cur_d = 4;

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            rc <= 0;
        end else begin
            rc <= rc + 1;
            if (rc < 8) hdr <= {hdr[27:0], io_out};
            if (rc >= 8 && io_oe != 4'h0) oe_bad <= 1'b1;
        end
    end

    always @(negedge sck) begin
        int j;
        logic [7:0] b;
        j = rc - 8 - cur_d;
        if (j >= 0) begin
            b = memf(hdr[23:0] + 24'(j / 2));
            io_in = (j % 2 == 0) ? b[7:4] : b[3:0];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Runs one burst; inj_at >= 0 pulses a second start at that sample index
    task automatic run_txn(input logic [23:0] a, input int n, input int d, input int inj_at);
        int first, cnt, last, cs_hi, bz, lim;
        first = 2 * (10 + d) - 1;
        cnt = 0; last = -1; cs_hi = -1; bz = -1;
        lim = first + 4 * n + 20;
        oe_bad = 1'b0;
        cur_d = d;
        @(negedge clk);
        start = 1'b1; addr = a; nbytes = 16'(n); dummy_cycles = 5'(d);
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            start = 1'b0;
            if (t == 0) begin
                check(cs_n == 1'b0 && sck == 1'b0, "R7", "select before clock", {cs_n, sck}, 2'b00);
                check(busy == 1'b1, "R8", "busy after accept", busy, 1);
            end
            if (t == 1) check(sck == 1'b1, "R1", "first rising sck", sck, 1);
            if (t == inj_at) begin
                start = 1'b1; addr = ~a; nbytes = 16'd9; dummy_cycles = 5'd0;
            end
            if (rd_valid) begin
                check(t == first + 4 * cnt, (cnt == 0) ? "R4" : "R5", "byte timing", t, first + 4 * cnt);
                check(rd_data == memf(a + 24'(cnt)), "R3", "byte value (R10)", rd_data, memf(a + 24'(cnt)));
                cnt++;
                last = t;
            end
            if (cs_n && cs_hi < 0) cs_hi = t;
            if (!busy && bz < 0) begin
                bz = t;
                break;
            end
        end
        check(cnt == n, "R3", "byte count", cnt, n);
        check(hdr == {8'hEB, a}, "R2", "header", hdr, {8'hEB, a});
        check(oe_bad == 1'b0, "R6", "lanes released after header", oe_bad, 0);
        check(cs_hi == last + 1, "R7", "deselect time", cs_hi, last + 1);
        check(bz == last + 3, "R8", "busy fall / idle gap", bz, last + 3);
    endtask

    localparam int NV = 6;
    // {addr[47:24], nbytes[23:8], dummy[7:0]}
    localparam logic [47:0] VEC [NV] = '{
        {24'h000000, 16'd1, 8'd4},
        {24'h123456, 16'd3, 8'd4},
        {24'hABCDEF, 16'd5, 8'd0},
        {24'hFFFFFE, 16'd4, 8'd7},
        {24'h00F0F0, 16'd2, 8'd1},
        {24'h5A5A5A, 16'd8, 8'd31}
    };

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && rd_valid == 1'b0 && io_oe == 4'h0,
              "R1", "reset state", {cs_n, sck, busy, rd_valid, io_oe}, 8'b1000_0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VEC[i]) begin
            run_txn(VEC[i][47:24], int'(VEC[i][23:8]), int'(VEC[i][7:0]), -1);
        end

        // R9: zero byte count leaves the block idle
        @(negedge clk);
        start = 1'b1; addr = 24'h777777; nbytes = 16'd0; dummy_cycles = 5'd4;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 6; t++) begin
            check(busy == 1'b0 && cs_n == 1'b1, "R9", "zero count ignored", {busy, cs_n}, 2'b01);
            @(negedge clk);
        end

        // R8: start during a transaction has no effect
        run_txn(24'h0C0FFE, 2, 4, 6);

        // R7: back-to-back request right after busy falls
        run_txn(24'h400000, 2, 2, -1);

        finish_run();
    end
endmodule